// File: doc/BRIEF.md
# Sector Page-Write Memory Controller

This block models the write side of a byte-wide nonvolatile array that is reprogrammed one 128-byte sector at a time. It is driven by an ordinary parallel memory bus (address, write data, read data and three active-low strobes) sampled on the system clock. Bytes that the host writes are gathered in a sector buffer. When the host stops writing for a set number of cycles, the block starts a timed cycle on its own. That cycle erases the whole sector and programs the buffered bytes into the backing array.

While the cycle runs, reads do not return array contents. They return a status word built from the last loaded byte. Bit 7 of that word is inverted, and bit 6 flips on every read, so software can poll for completion. Once the cycle ends, reads return true array data.

The bus has no back-pressure and no valid/ready pair. A write strobe is either taken as a byte load or dropped silently. The host learns that the array is busy only by polling.

The default array holds 16 sectors so that it elaborates at a small size. Setting `SEC_W` to 10 gives the full 1024-sector (128K x 8) array. `PROG_CYC` must be at least 128, because the sector is written one byte per cycle inside the busy period.

Top module: `sector_page_writer`

## Requirements
- R1: Address bits [6:0] select the byte within a sector, and bits [SEC_W+6:7] select the sector. A loaded byte is stored at exactly that sector and offset when programming completes.
- R2: A cycle is a load cycle only when `ce_n` and `we_n` are both low and `oe_n` is high. The address is taken in the first cycle of the load. The data is taken in the last cycle of the load, before the strobes release.
- R3: Bytes of a sector may be loaded in any order, and each lands at its own offset.
- R4: Programming starts only after `LOAD_WIN` consecutive clock cycles with no load in progress. A new load that begins inside the window restarts the count, so loading continues.
- R5: During a loading period, a load whose sector field differs from that of the first load is ignored.
- R6: Programming first erases the whole sector. Every byte of the sector that was not loaded reads back as `FILL` (8'hFF by default).
- R7: While programming is in progress, a read of any address returns the last accepted loaded byte with bit 7 inverted.
- R8: While programming is in progress, bit 6 of each read result alternates. The first read after programming starts returns 1, and each new read strobe flips it. Bits [5:0] carry the last loaded byte.
- R9: The programming period lasts `PROG_CYC` clock cycles. After it ends, reads return true array data.
- R10: Write strobes during programming are ignored. They neither change the data being programmed nor start a further cycle.
- R11: Holding `oe_n` low or `ce_n` high during a `we_n` pulse loads nothing and starts no program cycle.
- R12: After reset, the block is idle and `dout` is 8'h00 whenever no read (`ce_n` low, `oe_n` low, `we_n` high) is in progress. Read data appears one clock after the read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | SEC_W+7 | Byte address: sector field above a 7-bit offset |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status word; 0 when not reading |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |

## Verification
The assertions take for granted that the strobes come from one bus master and change only between clock edges. They also assume that `addr` and `din` are steady for the whole of a read. The checks on the length of the busy period and on the status word further assume that the host does not read and load in the same cycle. The stimulus changes every input on the falling clock edge, and it never drives a read and a write strobe together. Each read or write is a separate strobe pulse with an idle cycle after it, so every read strobe is a new read for the toggle bit.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } wstate_e;
endpackage

// File: rtl/swp_bus_decode.sv
// Turns the three bus strobes into load/read levels and their edges.
module swp_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_act,
  output logic wr_start,
  output logic wr_end,
  output logic rd_act,
  output logic rd_start
);
  logic wr_q, rd_q;

  assign wr_act   = ~ce_n & ~we_n & oe_n;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end
endmodule

// File: rtl/swp_seq.sv
// Load window timer, sector match and timed erase/program sequencer.
module swp_seq
  import swp_pkg::*;
#(
  parameter int SEC_W    = 4,
  parameter int OFF_W    = 7,
  parameter int LOAD_WIN = 7500,
  parameter int PROG_CYC = 500000,
  localparam int AW      = SEC_W + OFF_W,
  localparam int WW      = $clog2(LOAD_WIN + 1),
  localparam int PW      = $clog2(PROG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic             wr_start,
  input  logic             wr_end,
  input  logic [AW-1:0]    addr,
  output logic             busy,
  output logic             buf_we,
  output logic [OFF_W-1:0] buf_idx,
  output logic             buf_clr,
  output logic [SEC_W-1:0] cyc_sec,
  output logic             prog_we,
  output logic [OFF_W-1:0] prog_idx
);
  localparam int SEC_BYTES = 1 << OFF_W;

  wstate_e          state;
  logic             ld_ok;
  logic [WW-1:0]    wcnt;
  logic [PW-1:0]    pcnt;
  logic [SEC_W-1:0] a_sec;

  assign a_sec    = addr[AW-1:OFF_W];
  assign busy     = (state == ST_PROG);
  assign buf_we   = wr_end & ld_ok & (state == ST_LOAD);
  assign prog_we  = busy & (pcnt < PW'(SEC_BYTES));
  assign prog_idx = pcnt[OFF_W-1:0];
  assign buf_clr  = busy & (pcnt == PW'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ld_ok   <= 1'b0;
      buf_idx <= '0;
      cyc_sec <= '0;
      wcnt    <= '0;
      pcnt    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wr_start) begin
            state   <= ST_LOAD;
            cyc_sec <= a_sec;
            buf_idx <= addr[OFF_W-1:0];
            ld_ok   <= 1'b1;
            wcnt    <= '0;
          end
        end
        ST_LOAD: begin
          if (wr_start) begin
            buf_idx <= addr[OFF_W-1:0];
            ld_ok   <= (a_sec == cyc_sec);
          end
          if (wr_act) begin
            wcnt <= '0;
          end else if (wcnt == WW'(LOAD_WIN - 1)) begin
            state <= ST_PROG;
            pcnt  <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (wr_start) ld_ok <= 1'b0;
          if (pcnt == PW'(PROG_CYC - 1)) begin
            state <= ST_IDLE;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swp_buf.sv
// Sector buffer: one byte and one loaded flag per offset.
module swp_buf #(
  parameter int OFF_W = 7,
  localparam int SEC_BYTES = 1 << OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFF_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic             clr,
  input  logic [OFF_W-1:0] ridx,
  output logic [7:0]       rdata,
  output logic             rvalid
);
  logic [7:0]           bytes [SEC_BYTES];
  logic [SEC_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) bytes[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  assign rdata  = bytes[ridx];
  assign rvalid = vld[ridx];
endmodule

// File: rtl/sector_page_writer.sv
module sector_page_writer #(
  parameter int         SEC_W    = 4,
  parameter int         LOAD_WIN = 7500,
  parameter int         PROG_CYC = 500000,
  parameter logic [7:0] FILL     = 8'hFF,
  localparam int        OFF_W    = 7,
  localparam int        AW       = SEC_W + OFF_W,
  localparam int        DEPTH    = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n
);
  logic             wr_act, wr_start, wr_end, rd_act, rd_start;
  logic             busy, buf_we, buf_clr, prog_we, rvalid;
  logic [OFF_W-1:0] buf_idx, prog_idx;
  logic [SEC_W-1:0] cyc_sec;
  logic [7:0]       data_hold, last_data, rdata;
  logic             tog, tog_n;
  logic [7:0]       mem [DEPTH];

  swp_bus_decode u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end),
    .rd_act(rd_act), .rd_start(rd_start)
  );

  swp_seq #(.SEC_W(SEC_W), .OFF_W(OFF_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end),
    .addr(addr), .busy(busy), .buf_we(buf_we), .buf_idx(buf_idx), .buf_clr(buf_clr),
    .cyc_sec(cyc_sec), .prog_we(prog_we), .prog_idx(prog_idx)
  );

  swp_buf #(.OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(buf_idx), .wdata(data_hold),
    .clr(buf_clr), .ridx(prog_idx), .rdata(rdata), .rvalid(rvalid)
  );

  // Data follows din while the load strobe is held; the final value is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_hold <= '0;
      last_data <= '0;
    end else begin
      if (wr_act) data_hold <= din;
      if (buf_we) last_data <= data_hold;
    end
  end

  // Erase and program merged: each offset gets buffered data or the fill value.
  always_ff @(posedge clk) begin
    if (prog_we) mem[{cyc_sec, prog_idx}] <= rvalid ? rdata : FILL;
  end

  assign tog_n = rd_start ? ~tog : tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog  <= 1'b0;
      dout <= '0;
    end else begin
      tog <= busy ? tog_n : 1'b0;
      if (!rd_act)   dout <= '0;
      else if (busy) dout <= {~last_data[7], tog_n, last_data[5:0]};
      else           dout <= mem[addr];
    end
  end
endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
  parameter int PROG_CYC = 500000,
  localparam int CW = $clog2(PROG_CYC + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_act,
  input logic       rd_act,
  input logic       rd_start,
  input logic       buf_we,
  input logic       prog_we,
  input logic       tog,
  input logic [7:0] last_data,
  input logic [7:0] dout
);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;
  end

  p_idle_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wr_act));

  p_prog_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == CW'(PROG_CYC));

  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);

  p_last_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(last_data));

  p_array_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> busy);

  p_poll_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_act |=> dout[7] != last_data[7]);

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_start |=> tog != $past(tog));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> dout == 8'h00);
endmodule

bind sector_page_writer swp_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_act(wr_act), .rd_act(rd_act),
  .rd_start(rd_start), .buf_we(buf_we), .prog_we(prog_we), .tog(tog),
  .last_data(last_data), .dout(dout)
);

// File: tb/sim_sector_page_writer.sv
module sim_sector_page_writer;
  localparam int SEC_W = 4;
  localparam int AW    = SEC_W + 7;
  localparam int LWIN  = 20;
  localparam int PCYC  = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit armed = 1'b0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sector_page_writer #(.SEC_W(SEC_W), .LOAD_WIN(LWIN), .PROG_CYC(PCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n)
  );

  function automatic logic [AW-1:0] ad(input int sec, input int off);
    return AW'((sec << 7) | off);
  endfunction

  task automatic check_eq(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item once the read result is registered.
  always @(negedge clk) begin
    if (armed) begin
      check_eq(dout, exp_q.pop_front(), tag_q.pop_front());
      armed = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 armed = 1'b1;
    wait (armed == 1'b0);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq(dout, 8'h00, "R12 idle output after reset");

    // Phase A: scattered loads into sector 2, one stray sector.
    wr_byte(ad(2, 5), 8'hA5);
    wr_byte(ad(2, 127), 8'h7E);
    wr_byte(ad(2, 0), 8'h11);
    wr_byte(ad(3, 1), 8'h99);          // R5 stray sector
    wr_byte(ad(2, 64), 8'h3C);
    idle(30);
    rd_chk(ad(2, 5), 8'hFC, "R7 poll first read");
    rd_chk(ad(2, 5), 8'hBC, "R8 toggle second read");
    rd_chk(ad(9, 3), 8'hFC, "R8 toggle third read");
    wr_byte(ad(2, 5), 8'h00);          // R10 write while busy
    idle(235);
    rd_chk(ad(2, 0), 8'hBC, "R9 still busy near end");
    idle(60);
    rd_chk(ad(2, 5), 8'hA5, "R1 R10 byte at offset 5");
    rd_chk(ad(2, 127), 8'h7E, "R3 byte at offset 127");
    rd_chk(ad(2, 0), 8'h11, "R3 byte at offset 0");
    rd_chk(ad(2, 64), 8'h3C, "R9 true data after cycle");
    rd_chk(ad(2, 1), 8'hFF, "R5 stray byte not taken");
    rd_chk(ad(2, 100), 8'hFF, "R6 erased unloaded byte");

    // Phase B: blocked strobes, then window restart.
    @(negedge clk);
    addr = ad(2, 5); din = 8'h55; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(3);
    ce_n = 1'b1;
    oe_n = 1'b1;
    idle(3);
    we_n = 1'b1;
    idle(40);
    rd_chk(ad(2, 5), 8'hA5, "R11 blocked strobes load nothing");

    wr_byte(ad(4, 0), 8'h80);
    idle(15);
    rd_chk(ad(2, 5), 8'hA5, "R4 not busy inside window");
    wr_byte(ad(4, 2), 8'h42);
    idle(15);
    rd_chk(ad(2, 5), 8'hA5, "R4 window restarted");
    // R2: address from first load cycle, data from last.
    @(negedge clk);
    addr = ad(4, 3); din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    addr = ad(4, 9); din = 8'h33;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    idle(25);
    rd_chk(ad(4, 0), 8'hF3, "R7 R8 status from last load");
    idle(320);
    rd_chk(ad(4, 0), 8'h80, "R1 sector 4 offset 0");
    rd_chk(ad(4, 2), 8'h42, "R3 sector 4 offset 2");
    rd_chk(ad(4, 3), 8'h33, "R2 address and data capture");
    rd_chk(ad(4, 9), 8'hFF, "R2 later address unused");
    rd_chk(ad(4, 1), 8'hFF, "R6 sector 4 erased byte");
    idle(2);
    check_eq(dout, 8'h00, "R12 idle output between reads");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule